// File: doc/BRIEF.md
# RISC Instruction Field Decoder

This block turns one 32-bit instruction word of a 64-bit RISC integer pipeline into a decoded control bundle. The bundle carries an instruction class, the three raw register indices, a destination index with a write enable, a 64-bit immediate with a flag that selects it as the second operand, an ALU operation code, memory access attributes, the jump kind, a branch condition, a nop flag and an illegal-instruction flag. Execution, memory access and the register file belong to the stages that consume the bundle.

The decode logic is combinational and the bundle is captured in one output register stage. The word presented on `instr_i` at a rising clock edge therefore appears on the outputs after that edge. A synchronous active-high reset loads a bubble: class nop with the nop flag set. Instructions that would write the hardwired zero register (index 31) collapse to nops. Floating-point operate and floating-point memory opcodes are outside the supported set and are reported as illegal.

Class codes on `cls_o`: 0 nop, 1 privileged call, 2 address compute, 3 load, 4 store, 5 integer ALU, 6 cycle-counter read, 7 register jump, 8 branch, 9 illegal.

Top module: `rid_decoder`

## Requirements
- R1: A rising edge with `rst` high makes every output zero except `nop_o`=1 (class 0), regardless of `instr_i`.
- R2: The outputs show the decode of the word sampled at the previous rising edge; `ra_o`, `rb_o`, `rc_o` always equal word bits 25:21, 20:16 and 4:0.
- R3: In opcodes 0x10 to 0x13 with word bit 12 set and a legal function, `use_imm_o`=1 and `imm_o` is word bits 20:13 zero-extended; with bit 12 clear `use_imm_o`=0 and `imm_o`=0.
- R4: Any opcode 0x10 to 0x13 word whose rc (bits 4:0) is 31 is a nop, even when its function is unknown.
- R5: Opcodes 0x10 to 0x13 accept only their listed 7-bit functions (word bits 11:5); a legal one gives class 5, `wr_en_o`=1, `dst_o`=rc and `alu_op_o`={opcode[1:0], function}; any other function gives class 9.
- R6: Opcodes 0x08 and 0x09 give class 2, `dst_o`=ra, `imm_o`= sign-extended bits 15:0, shifted left 16 for 0x09; ra=31 makes either a nop.
- R7: Memory opcodes 0x0A-0x0F and 0x28-0x2F give class 3 (load) or 4 (store), `mem_size_o` 0 byte, 1 word, 2 longword, 3 quadword, `mem_lock_o` for 0x2A, 0x2B, 0x2E, 0x2F, `imm_o` the sign-extended displacement; loads write ra.
- R8: A load with ra=31 is a nop (prefetch hint); a store with ra=31 stays a store.
- R9: Opcode 0x00 gives class 1 with `imm_o` equal to word bits 25:0 zero-extended.
- R10: Opcode 0x1A gives class 7 with `jmp_kind_o`= bits 15:14 (0 jump, 1 call, 2 return) and writes ra unless ra=31; kind 3 gives class 9.
- R11: In opcode 0x18, low halfword 0x4000 or 0x4400 is a nop, 0xC000 gives class 6 writing ra (nop when ra=31), any other value gives class 9.
- R12: Opcodes 0x30/0x34 give class 8 with `br_cond_o`=0 and write ra unless ra=31; 0x38-0x3F give class 8 with `br_cond_o`={1, opcode[2:0]} and no write; `imm_o` is bits 20:0 sign-extended and shifted left 2.
- R13: Every other opcode, including 0x14-0x17, 0x22, 0x23, 0x26, 0x27 and 0x31-0x33, 0x35-0x37, gives class 9 with `illegal_o`=1, `wr_en_o`=0 and `nop_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| cls_o | output | 4 | Instruction class code |
| nop_o | output | 1 | Decoded as no operation |
| illegal_o | output | 1 | Unsupported encoding |
| wr_en_o | output | 1 | Destination register is written |
| dst_o | output | 5 | Destination register index |
| ra_o | output | 5 | Raw ra field |
| rb_o | output | 5 | Raw rb field |
| rc_o | output | 5 | Raw rc field |
| use_imm_o | output | 1 | Immediate replaces the second register operand |
| imm_o | output | XLEN | Immediate or literal value |
| alu_op_o | output | 9 | Operate group and function |
| mem_size_o | output | 2 | Access size for memory classes |
| mem_lock_o | output | 1 | Locked load or conditional store |
| jmp_kind_o | output | 2 | Register jump kind |
| br_cond_o | output | 4 | Branch condition, 0 for unconditional |

## Verification
The bench aims at the zero-register rules: an operate word with rc=31 and a bad function must become a nop rather than illegal, and a load to register 31 must vanish while a store from it survives; a design with the priorities swapped would flag illegal words or drop stores. It also pushes the immediate extremes: the most negative branch displacement, a high-half address offset with bit 15 set, and literal 0xFF, where a wrong sign extension or shift shows up in the upper bits. Jump kind 3, unlisted halfwords in the barrier group and the floating-point opcodes must report illegal without a write enable; a decoder that fell through to a default class would write a register.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam int OPC_W = 6;
  localparam int REG_W = 5;
  localparam int FN_W  = 7;
  localparam int ALU_W = 2 + FN_W;
  localparam logic [REG_W-1:0] ZERO_REG = 5'd31;

  typedef enum logic [3:0] {
    CLS_NOP     = 4'd0,
    CLS_PAL     = 4'd1,
    CLS_ADDR    = 4'd2,
    CLS_LOAD    = 4'd3,
    CLS_STORE   = 4'd4,
    CLS_ALU     = 4'd5,
    CLS_CCNT    = 4'd6,
    CLS_JUMP    = 4'd7,
    CLS_BRANCH  = 4'd8,
    CLS_ILLEGAL = 4'd9
  } cls_e;

  typedef enum logic [2:0] {
    IMM_NONE, IMM_LIT, IMM_DISP, IMM_HIGH, IMM_BR, IMM_PAL
  } imm_e;

  typedef struct packed {
    cls_e             cls;
    logic             nop;
    logic             illegal;
    logic             we;
    logic [REG_W-1:0] dst;
    logic             use_imm;
    logic [ALU_W-1:0] alu_op;
    logic [1:0]       size;
    logic             lock;
    logic [1:0]       jkind;
    logic [3:0]       cond;
  } ctl_t;
endpackage

// File: rtl/rid_imm.sv
module rid_imm #(
  parameter int XLEN = 64
) (
  input  logic [31:0]     iw,
  input  rid_pkg::imm_e   kind,
  output logic [XLEN-1:0] imm
);
  import rid_pkg::*;

  always_comb begin
    case (kind)
      IMM_LIT:  imm = {{(XLEN-8){1'b0}}, iw[20:13]};
      IMM_DISP: imm = {{(XLEN-16){iw[15]}}, iw[15:0]};
      IMM_HIGH: imm = {{(XLEN-32){iw[15]}}, iw[15:0], 16'h0000};
      IMM_BR:   imm = {{(XLEN-23){iw[20]}}, iw[20:0], 2'b00};
      IMM_PAL:  imm = {{(XLEN-26){1'b0}}, iw[25:0]};
      default:  imm = '0;
    endcase
  end
endmodule

// File: rtl/rid_opfn.sv
module rid_opfn (
  input  logic [1:0] grp,
  input  logic [6:0] fn,
  output logic       legal
);
  always_comb begin
    legal = 1'b0;
    case (grp)
      2'd0: case (fn)
        7'h00, 7'h02, 7'h09, 7'h0b, 7'h12, 7'h1b, 7'h1d, 7'h20, 7'h22,
        7'h29, 7'h2b, 7'h2d, 7'h32, 7'h3b, 7'h3d, 7'h4d, 7'h6d: legal = 1'b1;
        default: legal = 1'b0;
      endcase
      2'd1: case (fn)
        7'h00, 7'h08, 7'h14, 7'h16, 7'h20, 7'h24, 7'h26, 7'h28, 7'h40,
        7'h44, 7'h46, 7'h48, 7'h64, 7'h66: legal = 1'b1;
        default: legal = 1'b0;
      endcase
      2'd2: case (fn)
        7'h02, 7'h06, 7'h0b, 7'h12, 7'h16, 7'h1b, 7'h22, 7'h26, 7'h2b,
        7'h30, 7'h31, 7'h32, 7'h34, 7'h36, 7'h39, 7'h3b, 7'h3c, 7'h52,
        7'h57, 7'h5a, 7'h62, 7'h67, 7'h6a, 7'h72, 7'h77, 7'h7a: legal = 1'b1;
        default: legal = 1'b0;
      endcase
      default: case (fn)
        7'h00, 7'h20, 7'h30: legal = 1'b1;
        default: legal = 1'b0;
      endcase
    endcase
  end
endmodule

// File: rtl/rid_memdec.sv
module rid_memdec (
  input  logic [5:0] opc,
  output logic       is_mem,
  output logic       is_load,
  output logic [1:0] size,
  output logic       lock
);
  always_comb begin
    is_mem  = 1'b0;
    is_load = 1'b0;
    size    = 2'd0;
    lock    = 1'b0;
    if (opc[5:3] == 3'b101) begin
      is_mem  = 1'b1;
      is_load = ~opc[2];
      size    = {1'b1, opc[0]};
      lock    = opc[1];
    end else begin
      case (opc)
        6'h0a: begin is_mem = 1'b1; is_load = 1'b1; size = 2'd0; end
        6'h0b: begin is_mem = 1'b1; is_load = 1'b1; size = 2'd3; end
        6'h0c: begin is_mem = 1'b1; is_load = 1'b1; size = 2'd1; end
        6'h0d: begin is_mem = 1'b1; size = 2'd1; end
        6'h0e: begin is_mem = 1'b1; size = 2'd0; end
        6'h0f: begin is_mem = 1'b1; size = 2'd3; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rid_decoder.sv
module rid_decoder #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     instr_i,
  output logic [3:0]      cls_o,
  output logic            nop_o,
  output logic            illegal_o,
  output logic            wr_en_o,
  output logic [4:0]      dst_o,
  output logic [4:0]      ra_o,
  output logic [4:0]      rb_o,
  output logic [4:0]      rc_o,
  output logic            use_imm_o,
  output logic [XLEN-1:0] imm_o,
  output logic [8:0]      alu_op_o,
  output logic [1:0]      mem_size_o,
  output logic            mem_lock_o,
  output logic [1:0]      jmp_kind_o,
  output logic [3:0]      br_cond_o
);
  import rid_pkg::*;

  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] fa, fb, fc;
  logic             fn_ok, m_mem, m_load, m_lock;
  logic [1:0]       m_size;
  imm_e             ik;
  ctl_t             c, q;
  logic [XLEN-1:0]  imm_d, imm_q;
  logic [REG_W-1:0] ra_q, rb_q, rc_q;

  assign opc = instr_i[31:26];
  assign fa  = instr_i[25:21];
  assign fb  = instr_i[20:16];
  assign fc  = instr_i[4:0];

  rid_opfn u_opfn (.grp(opc[1:0]), .fn(instr_i[11:5]), .legal(fn_ok));

  rid_memdec u_mem (
    .opc(opc), .is_mem(m_mem), .is_load(m_load), .size(m_size), .lock(m_lock)
  );

  rid_imm #(.XLEN(XLEN)) u_imm (.iw(instr_i), .kind(ik), .imm(imm_d));

  always_comb begin
    c     = '0;
    c.cls = CLS_NOP;
    ik    = IMM_NONE;
    case (opc)
      6'h00: begin
        c.cls = CLS_PAL; c.use_imm = 1'b1; ik = IMM_PAL;
      end
      6'h08, 6'h09: begin
        if (fa == ZERO_REG) c.nop = 1'b1;
        else begin
          c.cls = CLS_ADDR; c.we = 1'b1; c.dst = fa; c.use_imm = 1'b1;
          ik = opc[0] ? IMM_HIGH : IMM_DISP;
        end
      end
      6'h10, 6'h11, 6'h12, 6'h13: begin
        if (fc == ZERO_REG) c.nop = 1'b1;
        else if (!fn_ok) begin
          c.cls = CLS_ILLEGAL; c.illegal = 1'b1;
        end else begin
          c.cls = CLS_ALU; c.we = 1'b1; c.dst = fc;
          c.use_imm = instr_i[12];
          c.alu_op  = {opc[1:0], instr_i[11:5]};
          ik = instr_i[12] ? IMM_LIT : IMM_NONE;
        end
      end
      6'h18: begin
        case (instr_i[15:0])
          16'h4000, 16'h4400: c.nop = 1'b1;
          16'hc000: begin
            if (fa == ZERO_REG) c.nop = 1'b1;
            else begin c.cls = CLS_CCNT; c.we = 1'b1; c.dst = fa; end
          end
          default: begin c.cls = CLS_ILLEGAL; c.illegal = 1'b1; end
        endcase
      end
      6'h1a: begin
        if (instr_i[15:14] == 2'd3) begin
          c.cls = CLS_ILLEGAL; c.illegal = 1'b1;
        end else begin
          c.cls   = CLS_JUMP;
          c.jkind = instr_i[15:14];
          c.we    = (fa != ZERO_REG);
          c.dst   = (fa != ZERO_REG) ? fa : '0;
        end
      end
      6'h30, 6'h34: begin
        c.cls = CLS_BRANCH; c.use_imm = 1'b1; ik = IMM_BR;
        c.we  = (fa != ZERO_REG);
        c.dst = (fa != ZERO_REG) ? fa : '0;
      end
      6'h38, 6'h39, 6'h3a, 6'h3b, 6'h3c, 6'h3d, 6'h3e, 6'h3f: begin
        c.cls = CLS_BRANCH; c.use_imm = 1'b1; ik = IMM_BR;
        c.cond = {1'b1, opc[2:0]};
      end
      default: begin
        if (!m_mem) begin
          c.cls = CLS_ILLEGAL; c.illegal = 1'b1;
        end else if (m_load && fa == ZERO_REG) begin
          c.nop = 1'b1;
        end else begin
          c.cls     = m_load ? CLS_LOAD : CLS_STORE;
          c.we      = m_load;
          c.dst     = m_load ? fa : '0;
          c.use_imm = 1'b1;
          c.size    = m_size;
          c.lock    = m_lock;
          ik        = IMM_DISP;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      q.cls <= CLS_NOP;
      q.nop <= 1'b1;
      imm_q <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      rc_q  <= '0;
    end else begin
      q     <= c;
      imm_q <= (c.nop || c.illegal) ? '0 : imm_d;
      ra_q  <= fa;
      rb_q  <= fb;
      rc_q  <= fc;
    end
  end

  assign cls_o      = q.cls;
  assign nop_o      = q.nop;
  assign illegal_o  = q.illegal;
  assign wr_en_o    = q.we;
  assign dst_o      = q.dst;
  assign ra_o       = ra_q;
  assign rb_o       = rb_q;
  assign rc_o       = rc_q;
  assign use_imm_o  = q.use_imm;
  assign imm_o      = imm_q;
  assign alu_op_o   = q.alu_op;
  assign mem_size_o = q.size;
  assign mem_lock_o = q.lock;
  assign jmp_kind_o = q.jkind;
  assign br_cond_o  = q.cond;
endmodule

// File: rtl/rid_decoder_chk.sv
module rid_decoder_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     instr_i,
  input logic [3:0]      cls_o,
  input logic            nop_o,
  input logic            illegal_o,
  input logic            wr_en_o,
  input logic [4:0]      dst_o,
  input logic [4:0]      ra_o,
  input logic [4:0]      rb_o,
  input logic [4:0]      rc_o,
  input logic            use_imm_o,
  input logic [XLEN-1:0] imm_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1: a reset edge leaves a bubble
  a_r1_reset_bubble: assert property (@(posedge clk)
    armed && $past(rst) |-> nop_o && !wr_en_o && !illegal_o && cls_o == 4'd0);

  // R2: raw fields follow the word of the previous edge
  a_r2_fields: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) |->
      ra_o == $past(instr_i[25:21]) && rb_o == $past(instr_i[20:16]) &&
      rc_o == $past(instr_i[4:0]));

  // R3: literal operand in the operate groups
  a_r3_literal: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(instr_i[31:28] == 4'h4 && instr_i[12] &&
    instr_i[4:0] != 5'd31) && !illegal_o |->
      use_imm_o && imm_o == {{(XLEN-8){1'b0}}, $past(instr_i[20:13])});

  // R4: operate to register 31 is a nop
  a_r4_op_zero_nop: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(instr_i[31:28] == 4'h4 &&
    instr_i[4:0] == 5'd31) |-> nop_o && !illegal_o);

  // R4: no write is ever aimed at register 31
  a_r4_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> dst_o != 5'd31);

  // R13: illegal words never write and are not nops
  a_r13_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !wr_en_o && !nop_o && cls_o == 4'd9);
endmodule

bind rid_decoder rid_decoder_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .instr_i(instr_i), .cls_o(cls_o), .nop_o(nop_o),
  .illegal_o(illegal_o), .wr_en_o(wr_en_o), .dst_o(dst_o), .ra_o(ra_o),
  .rb_o(rb_o), .rc_o(rc_o), .use_imm_o(use_imm_o), .imm_o(imm_o)
);

// File: tb/rid_decoder_tb.sv
`timescale 1ns/1ps
module rid_decoder_tb;
  localparam int XLEN = 64;
  localparam int VW = 46 + XLEN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic [3:0] cls; logic nop, ill, we, uimm, lock;
  logic [4:0] dst, ra, rb, rc;
  logic [XLEN-1:0] imm;
  logic [8:0] aop; logic [1:0] msz, jk; logic [3:0] cond;
  int nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  rid_decoder #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .instr_i(instr), .cls_o(cls), .nop_o(nop),
    .illegal_o(ill), .wr_en_o(we), .dst_o(dst), .ra_o(ra), .rb_o(rb),
    .rc_o(rc), .use_imm_o(uimm), .imm_o(imm), .alu_op_o(aop),
    .mem_size_o(msz), .mem_lock_o(lock), .jmp_kind_o(jk), .br_cond_o(cond)
  );

  function automatic logic fn_listed(logic [1:0] g, logic [6:0] f);
    case (g)
      2'd0: return f inside {7'h00,7'h02,7'h09,7'h0b,7'h12,7'h1b,7'h1d,7'h20,
        7'h22,7'h29,7'h2b,7'h2d,7'h32,7'h3b,7'h3d,7'h4d,7'h6d};
      2'd1: return f inside {7'h00,7'h08,7'h14,7'h16,7'h20,7'h24,7'h26,7'h28,
        7'h40,7'h44,7'h46,7'h48,7'h64,7'h66};
      2'd2: return f inside {7'h02,7'h06,7'h0b,7'h12,7'h16,7'h1b,7'h22,7'h26,
        7'h2b,7'h30,7'h31,7'h32,7'h34,7'h36,7'h39,7'h3b,7'h3c,7'h52,7'h57,
        7'h5a,7'h62,7'h67,7'h6a,7'h72,7'h77,7'h7a};
      default: return f inside {7'h00,7'h20,7'h30};
    endcase
  endfunction

  // memory table: returns {valid, load, size, lock}
  function automatic logic [4:0] mem_row(logic [5:0] op);
    case (op)
      6'h0a: return 5'b1_1_00_0;  6'h0b: return 5'b1_1_11_0;
      6'h0c: return 5'b1_1_01_0;  6'h0d: return 5'b1_0_01_0;
      6'h0e: return 5'b1_0_00_0;  6'h0f: return 5'b1_0_11_0;
      6'h28: return 5'b1_1_10_0;  6'h29: return 5'b1_1_11_0;
      6'h2a: return 5'b1_1_10_1;  6'h2b: return 5'b1_1_11_1;
      6'h2c: return 5'b1_0_10_0;  6'h2d: return 5'b1_0_11_0;
      6'h2e: return 5'b1_0_10_1;  6'h2f: return 5'b1_0_11_1;
      default: return 5'b0;
    endcase
  endfunction

  function automatic logic [VW-1:0] model(logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [4:0] a = w[25:21], c = w[4:0];
    logic [3:0] k = 4'd0; logic n = 0, il = 0, e = 0, u = 0, lk = 0;
    logic [4:0] d = 5'd0; logic [XLEN-1:0] im = '0; logic [8:0] al = 9'd0;
    logic [1:0] sz = 2'd0, j = 2'd0; logic [3:0] cd = 4'd0;
    logic [4:0] mr = mem_row(op);
    logic [XLEN-1:0] brimm = {{(XLEN-23){w[20]}}, w[20:0], 2'b00};
    if (op == 6'h00) begin k = 1; u = 1; im = {{(XLEN-26){1'b0}}, w[25:0]}; end
    else if (op == 6'h08 || op == 6'h09) begin
      if (a == 31) n = 1;
      else begin
        k = 2; e = 1; d = a; u = 1;
        im = {{(XLEN-16){w[15]}}, w[15:0]};
        if (op == 6'h09) im = im << 16;
      end
    end else if (op >= 6'h10 && op <= 6'h13) begin
      if (c == 31) n = 1;
      else if (!fn_listed(op[1:0], w[11:5])) begin k = 9; il = 1; end
      else begin
        k = 5; e = 1; d = c; u = w[12]; al = {op[1:0], w[11:5]};
        if (w[12]) im = {{(XLEN-8){1'b0}}, w[20:13]};
      end
    end else if (op == 6'h18) begin
      if (w[15:0] == 16'h4000 || w[15:0] == 16'h4400) n = 1;
      else if (w[15:0] == 16'hc000) begin
        if (a == 31) n = 1; else begin k = 6; e = 1; d = a; end
      end else begin k = 9; il = 1; end
    end else if (op == 6'h1a) begin
      if (w[15:14] == 2'd3) begin k = 9; il = 1; end
      else begin k = 7; j = w[15:14]; if (a != 31) begin e = 1; d = a; end end
    end else if (op == 6'h30 || op == 6'h34) begin
      k = 8; u = 1; im = brimm; if (a != 31) begin e = 1; d = a; end
    end else if (op >= 6'h38) begin
      k = 8; u = 1; im = brimm; cd = {1'b1, op[2:0]};
    end else if (mr[4]) begin
      if (mr[3] && a == 31) n = 1;
      else begin
        k = mr[3] ? 4'd3 : 4'd4; e = mr[3]; d = mr[3] ? a : 5'd0; u = 1;
        im = {{(XLEN-16){w[15]}}, w[15:0]}; sz = mr[2:1]; lk = mr[0];
      end
    end else begin k = 9; il = 1; end
    return {k, n, il, e, d, w[25:21], w[20:16], w[4:0], u, im, al, sz, lk, j, cd};
  endfunction

  function automatic string tag_of(logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [4:0] mr = mem_row(op);
    if (op == 6'h00) return "R9";
    if (op == 6'h08 || op == 6'h09) return "R6";
    if (op >= 6'h10 && op <= 6'h13)
      return (w[4:0] == 31) ? "R4" : (w[12] ? "R3" : "R5");
    if (op == 6'h18) return "R11";
    if (op == 6'h1a) return "R10";
    if (op == 6'h30 || op == 6'h34 || op >= 6'h38) return "R12";
    if (mr[4]) return (mr[3] && w[25:21] == 31) ? "R8" : "R7";
    return "R13";
  endfunction

  task automatic check(string tag, logic [VW-1:0] exp);
    logic [VW-1:0] act;
    act = {cls, nop, ill, we, dst, ra, rb, rc, uimm, imm, aop, msz, lock, jk, cond};
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] w, string tag);
    instr = w;
    @(negedge clk);
    check(tag, model(w));
  endtask

  function automatic logic [31:0] opw(logic [5:0] op, logic [4:0] a, logic [4:0] b,
                                      logic [6:0] f, logic [4:0] c);
    return {op, a, b, 4'b0000, f, c};
  endfunction
  function automatic logic [31:0] litw(logic [5:0] op, logic [4:0] a, logic [7:0] l,
                                       logic [6:0] f, logic [4:0] c);
    return {op, a, l, 1'b1, f, c};
  endfunction

  localparam logic [VW-1:0] BUBBLE = {4'd0, 1'b1, {(VW-5){1'b0}}};

  initial begin
    logic [5:0] pool [0:19] = '{6'h00,6'h08,6'h09,6'h10,6'h11,6'h12,6'h13,6'h18,
      6'h1a,6'h30,6'h34,6'h39,6'h3f,6'h0a,6'h0b,6'h0d,6'h28,6'h2b,6'h2e,6'h16};
    logic [6:0] fpick [0:11] = '{7'h00,7'h20,7'h30,7'h09,7'h14,7'h66,7'h3c,
      7'h7a,7'h2d,7'h6d,7'h02,7'h7f};
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 reset state", BUBBLE);
    rst = 1'b0;

    run(opw(6'h10, 5'd3, 5'd17, 7'h20, 5'd9), "R2 field split");
    run(litw(6'h10, 5'd1, 8'hff, 7'h20, 5'd1), "R3 literal 0xff");
    run(litw(6'h12, 5'd4, 8'h80, 7'h3c, 5'd6), "R3 literal shift");
    run(opw(6'h11, 5'd2, 5'd2, 7'h7f, 5'd31), "R4 rc31 beats bad func");
    run(opw(6'h13, 5'd5, 5'd6, 7'h30, 5'd7), "R5 multiply high");
    run(opw(6'h12, 5'd5, 5'd6, 7'h7f, 5'd7), "R5 unknown func");
    run({6'h09, 5'd2, 5'd31, 16'h8001}, "R6 high offset negative");
    run({6'h08, 5'd31, 5'd4, 16'h0010}, "R6 ra31 nop");
    run({6'h2f, 5'd3, 5'd4, 16'h0008}, "R7 conditional quad store");
    run({6'h0a, 5'd3, 5'd4, 16'hfffc}, "R7 byte load");
    run({6'h29, 5'd31, 5'd4, 16'h0000}, "R8 prefetch");
    run({6'h0e, 5'd31, 5'd4, 16'h0001}, "R8 store of r31");
    run({6'h00, 26'h3ffffff}, "R9 call number");
    run({6'h1a, 5'd26, 5'd9, 2'd3, 14'h0}, "R10 kind 3");
    run({6'h1a, 5'd31, 5'd26, 2'd2, 14'h0}, "R10 return");
    run({6'h18, 5'd5, 5'd0, 16'h4400}, "R11 barrier");
    run({6'h18, 5'd31, 5'd0, 16'hc000}, "R11 counter to r31");
    run({6'h18, 5'd5, 5'd0, 16'hc000}, "R11 counter read");
    run({6'h18, 5'd5, 5'd0, 16'h1234}, "R11 unknown");
    run({6'h3f, 5'd8, 21'h100000}, "R12 min displacement");
    run({6'h34, 5'd26, 21'h000003}, "R12 link write");
    run({6'h16, 26'h0}, "R13 fp operate");
    run({6'h31, 26'h5}, "R13 fp branch");
    run({6'h22, 5'd1, 5'd2, 16'h0}, "R13 fp load");

    instr = opw(6'h10, 5'd1, 5'd2, 7'h20, 5'd3);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", BUBBLE);
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if ($urandom_range(0, 9) < 8) w[31:26] = pool[$urandom_range(0, 19)];
      if (w[31:28] == 4'h4 && $urandom_range(0, 1) == 1)
        w[11:5] = fpick[$urandom_range(0, 11)];
      if (w[31:26] == 6'h18 && $urandom_range(0, 1) == 1)
        w[15:0] = ($urandom_range(0, 1) == 1) ? 16'hc000 : 16'h4000;
      run(w, tag_of(w));
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #100000;
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule